// File: doc/BRIEF.md
# Watchdog and Interval Timer

An 8-bit up-counter advances on pulses from a free-running prescaler. The prescaler divides the peripheral clock by one of eight ratios. The block runs in one of two modes. In interval mode, reaching the top count latches a flag, and that flag drives a level interrupt request. In watchdog mode, reaching the top count latches a sticky overflow flag. It also starts a fixed-length active-low overflow pulse for board reset logic and emits a one-cycle internal reset request. The reset request is an output only; the block never resets itself.

Software writes 16-bit words. The upper byte of each word must carry a per-register key, and a write with the wrong key changes nothing. The counter value 0xFF is the overflow condition itself. Loading 0xFF therefore fires on the next cycle, whatever ratio is selected. The prescaler is never cleared by register writes, so the first increment after an enable or a counter write lands somewhere between one clock and one full divided period later.

Top module: `wdt_timer`

## Requirements
- R1: After the asynchronous reset, the counter, `csr_o` and `rcsr_o` read 0, the timer is stopped, `irq_o` and `rst_req_o` are low, and `ovf_no` is high.
- R2: When `csr_o[6]` (enable) is 1, the counter advances by one, wrapping 0xFF to 0x00, on each terminal pulse of a prescaler that runs freely from reset. Field `csr_o[2:0]` values 0..7 select the ratios 1, 4, 16, 32, 64, 256, 1024 and 4096.
- R3: A counter value of 0xFF while enabled counts as overflow. A keyed write of 0xFF to the counter raises the overflow effect on the cycle after the counter shows 0xFF, independent of the ratio.
- R4: In interval mode (`csr_o[5]`=0), overflow sets `csr_o[7]`. `irq_o` is high exactly while `csr_o[7]` is 1 and interval mode is selected.
- R5: A keyed control write with bit 7 equal to 0 clears `csr_o[7]` only when the counter is not 0xFF. Writing bit 7 as 1 never sets it.
- R6: In watchdog mode (`csr_o[5]`=1), entering overflow sets `rcsr_o[7]`. If `rcsr_o[6]` (reset enable) is 1 and `rcsr_o[7]` was 0, `rst_req_o` pulses high for exactly one cycle.
- R7: While `rcsr_o[7]` is 1, further watchdog overflows give no `rst_req_o`. A keyed reset-register write with bit 7 equal to 0 clears it.
- R8: Each watchdog overflow drives `ovf_no` low for exactly 128 clocks, starting in the same cycle as the reset request would.
- R9: A write takes effect only with key 0x5A for the counter (`wr_sel_i`=0), 0xA5 for control (`wr_sel_i`=1) and 0xC3 for the reset register (`wr_sel_i`=2) in `wr_data_i[15:8]`. Any other key leaves the register unchanged.
- R10: While `csr_o[6]` is 0 and there is no keyed counter write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Target: 0 counter, 1 control, 2 reset register, 3 none |
| wr_data_i | input | 16 | Key in [15:8], value in [7:0] |
| cnt_o | output | 8 | Counter value |
| csr_o | output | 8 | Control: [7] interval flag, [6] enable, [5] watchdog mode, [2:0] clock select |
| rcsr_o | output | 8 | Reset register: [7] watchdog flag, [6] reset enable |
| irq_o | output | 1 | Interval interrupt request level |
| ovf_no | output | 1 | Active-low overflow pulse |
| rst_req_o | output | 1 | One-cycle internal reset request |

## Verification
The properties assume that write inputs are steady around each rising edge and that reset is the only way registers return to zero. The bench changes inputs only on falling edges. The one-cycle width of the reset request relies on the counter leaving 0xFF only through an increment or a write. Every one of those exits needs at least one clock after entry, which the stimulus respects because it never rewrites 0xFF on the cycle right after the counter reaches it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CSR  = 2'd1,
    SEL_RCSR = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  // log2 of the division ratio per clock-select code
  function automatic int unsigned tap_shift(input logic [2:0] cs);
    case (cs)
      3'd0:    return 0;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 8;
      3'd6:    return 10;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] clk_sel_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  always_comb begin
    mask   = DIV_W'((64'd1 << wdt_pkg::tap_shift(clk_sel_i)) - 64'd1);
    tick_o = (div_q & mask) == mask;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (start_i)        left_q <= CW'(LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign active_o = left_q != '0;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int         CNT_W     = 8,
  parameter int         DIV_W     = 12,
  parameter int         PULSE_LEN = 128,
  parameter logic [7:0] KEY_CNT   = 8'h5A,
  parameter logic [7:0] KEY_CSR   = 8'hA5,
  parameter logic [7:0] KEY_RCSR  = 8'hC3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [15:0]      wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       csr_o,
  output logic [7:0]       rcsr_o,
  output logic             irq_o,
  output logic             ovf_no,
  output logic             rst_req_o
);
  import wdt_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       cs_q;
  logic             en_q, mode_q, iflag_q;
  logic             wflag_q, rst_en_q, hit_q, rst_req_q;
  logic             tick, at_max, hit, wd_rise, pulse_on;
  logic             wr_cnt, wr_csr, wr_rcsr;

  assign wr_cnt  = wr_en_i && (wr_sel_i == SEL_CNT)  && (wr_data_i[15:8] == KEY_CNT);
  assign wr_csr  = wr_en_i && (wr_sel_i == SEL_CSR)  && (wr_data_i[15:8] == KEY_CSR);
  assign wr_rcsr = wr_en_i && (wr_sel_i == SEL_RCSR) && (wr_data_i[15:8] == KEY_RCSR);

  wdt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_sel_i (cs_q),
    .tick_o    (tick)
  );

  assign at_max  = cnt_q == CNT_MAX;
  assign hit     = en_q && at_max;
  assign wd_rise = hit && !hit_q && mode_q;   // entry into overflow, watchdog mode

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit;
      if (wr_cnt)            cnt_q <= wr_data_i[CNT_W-1:0];
      else if (en_q && tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= '0;
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      iflag_q <= 1'b0;
    end else begin
      if (wr_csr) begin
        cs_q   <= wr_data_i[2:0];
        mode_q <= wr_data_i[5];
        en_q   <= wr_data_i[6];
        if (!wr_data_i[7] && !at_max) iflag_q <= 1'b0;
      end
      if (hit && !mode_q) iflag_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wflag_q   <= 1'b0;
      rst_en_q  <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= wd_rise && rst_en_q && !wflag_q;
      if (wr_rcsr) begin
        rst_en_q <= wr_data_i[6];
        if (!wr_data_i[7]) wflag_q <= 1'b0;
      end
      if (wd_rise) wflag_q <= 1'b1;
    end
  end

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wd_rise),
    .active_o (pulse_on)
  );

  assign cnt_o     = cnt_q;
  assign csr_o     = {iflag_q, en_q, mode_q, 2'b00, cs_q};
  assign rcsr_o    = {wflag_q, rst_en_q, 6'b0};
  assign irq_o     = iflag_q && !mode_q;
  assign ovf_no    = !pulse_on;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [7:0]       csr_o,
  input logic [7:0]       rcsr_o,
  input logic             ovf_no,
  input logic             rst_req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_OVF_SETS_IFLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && csr_o[6] && !csr_o[5]) |=> csr_o[7]); // R3

  AST_IFLAG_STUCK_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && csr_o[7]) |=> csr_o[7]); // R5

  AST_RST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R6

  AST_RST_REQ_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> rcsr_o[7]); // R6

  AST_RST_REQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (!$past(rcsr_o[7]) && $past(rcsr_o[6]))); // R7

  AST_PULSE_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !ovf_no); // R8

  AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_o[6] && !(wr_en_i && wr_sel_i == 2'd0)) |=> $stable(cnt_o)); // R10
endmodule

bind wdt_timer wdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .cnt_o     (cnt_o),
  .csr_o     (csr_o),
  .rcsr_o    (rcsr_o),
  .ovf_no    (ovf_no),
  .rst_req_o (rst_req_o)
);

// File: tb/wdt_timer_tb.sv
`timescale 1ns/1ps
module wdt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [15:0] wr_data = '0;
  logic [7:0]  cnt, csr, rcsr;
  logic        irq, ovf_n, rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .cnt_o(cnt), .csr_o(csr), .rcsr_o(rcsr),
    .irq_o(irq), .ovf_no(ovf_n), .rst_req_o(rst_req)
  );

  // behavioural reference model
  int m_div, m_cnt, m_cs, m_pulse;
  bit m_en, m_mode, m_iflag, m_wflag, m_rsten, m_req, m_hitq;

  function automatic int ratio(input int cs);
    int r[8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
    return r[cs];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_cs = 0; m_pulse = 0;
      m_en = 0; m_mode = 0; m_iflag = 0; m_wflag = 0; m_rsten = 0; m_req = 0; m_hitq = 0;
    end else begin
      bit tick, full, hit, rise, kc, kr, kq;
      int n_cnt;
      tick = (m_div % ratio(m_cs)) == ratio(m_cs) - 1;
      full = m_cnt == 255;
      hit  = m_en && full;
      rise = hit && !m_hitq && m_mode;
      kc = wr_en && wr_sel == 0 && wr_data[15:8] == 8'h5A;
      kq = wr_en && wr_sel == 1 && wr_data[15:8] == 8'hA5;
      kr = wr_en && wr_sel == 2 && wr_data[15:8] == 8'hC3;
      m_req = rise && m_rsten && !m_wflag;
      if (rise) m_pulse = 128; else if (m_pulse > 0) m_pulse--;
      if (hit && !m_mode) m_iflag = 1;
      else if (kq && !wr_data[7] && !full) m_iflag = 0;
      if (rise) m_wflag = 1;
      else if (kr && !wr_data[7]) m_wflag = 0;
      if (kr) m_rsten = wr_data[6];
      n_cnt = kc ? int'(wr_data[7:0]) : (m_en && tick) ? (m_cnt + 1) % 256 : m_cnt;
      if (kq) begin m_cs = int'(wr_data[2:0]); m_mode = wr_data[5]; m_en = wr_data[6]; end
      m_cnt = n_cnt;
      m_hitq = hit;
      m_div = (m_div + 1) % 4096;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk(cnt == 8'(m_cnt), "R2", cnt, m_cnt);
    chk(csr == {m_iflag, m_en, m_mode, 2'b00, 3'(m_cs)}, "R4", csr,
        {m_iflag, m_en, m_mode, 2'b00, 3'(m_cs)});
    chk(irq == (m_iflag && !m_mode), "R4", irq, m_iflag && !m_mode);
    chk(rcsr == {m_wflag, m_rsten, 6'b0}, "R6", rcsr, {m_wflag, m_rsten, 6'b0});
    chk(rst_req == m_req, "R6", rst_req, m_req);
    chk(ovf_n == (m_pulse == 0), "R8", ovf_n, m_pulse == 0);
  end

  int req_pulses = 0, low_cycles = 0;
  always @(negedge clk) begin
    if (rst_req) req_pulses++;
    if (!ovf_n) low_cycles++;
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt == 0 && csr == 0 && rcsr == 0, "R1", {cnt, csr, rcsr}, 0);
    chk(ovf_n && !irq && !rst_req, "R1", {ovf_n, irq, rst_req}, 3'b100);
    idle(20);
    chk(cnt == 0, "R10", cnt, 0);

    // R2 divide by 4 from zero
    wr(1, 16'hA541);
    idle(400);
    chk(cnt >= 8'd99 && cnt <= 8'd101, "R2", cnt, 100);
    for (int cs = 0; cs < 8; cs++) begin
      wr(1, 16'hA540 | 16'(cs));
      wr(0, 16'h5A00);
      idle(300);
    end
    wr(1, 16'hA500);

    // R9 wrong keys
    wr(0, 16'h5A40);
    wr(0, 16'h0033);
    chk(cnt == 8'h40, "R9", cnt, 8'h40);
    wr(1, 16'h5A47);
    chk(csr[6:0] == 7'h00, "R9", csr, 0);

    // R3 write of 0xFF fires immediately at slowest ratio
    wr(0, 16'h5A10);
    wr(1, 16'hA547);
    wr(0, 16'h5AFF);
    @(negedge clk);
    chk(csr[7] == 1'b1, "R3", csr[7], 1);
    chk(irq == 1'b1, "R4", irq, 1);

    // R5 clear blocked at 0xFF
    wr(1, 16'hA587);
    wr(0, 16'h5AFF);
    idle(5);
    chk(cnt == 8'hFF, "R10", cnt, 8'hFF);
    wr(1, 16'hA507);
    chk(csr[7] == 1'b1, "R5", csr[7], 1);
    wr(0, 16'h5A20);
    wr(1, 16'hA507);
    chk(csr[7] == 1'b0 && !irq, "R5", {csr[7], irq}, 0);

    // R6 / R8 watchdog overflow
    wr(2, 16'hC340);
    wr(0, 16'h5AF0);
    req_pulses = 0; low_cycles = 0;
    wr(1, 16'hA560);
    idle(200);
    chk(req_pulses == 1, "R6", req_pulses, 1);
    chk(rcsr[7] == 1'b1, "R6", rcsr[7], 1);
    chk(low_cycles == 128, "R8", low_cycles, 128);
    wr(2, 16'h0000);
    chk(rcsr == 8'hC0, "R9", rcsr, 8'hC0);

    // R7 masked while flag set, resumes after clear
    req_pulses = 0; low_cycles = 0;
    idle(296);
    chk(req_pulses == 0, "R7", req_pulses, 0);
    chk(low_cycles == 128, "R8", low_cycles, 128);
    wr(2, 16'hC340);
    req_pulses = 0;
    idle(300);
    chk(req_pulses == 1, "R7", req_pulses, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule